// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Router

This block collects `32 × NUM_WORDS` level-sensitive interrupt lines and drives one interrupt output per CPU. It passes every input line through a two-stage synchronizer into a shared status vector. Each CPU owns a private set of enable words. A CPU's output is raised whenever any synchronized line is both high and enabled in that CPU's own enable words.

Software reaches the block over a simple 32-bit register bus with a valid/ready request and a one-cycle registered read response. The register space is split into consecutive per-CPU banks of `8 × NUM_WORDS` bytes. Each bank holds the enable words first and then the status words.

Within each group, the word at the lowest offset covers the highest-numbered lines. To steer a line to one CPU, software sets its enable bit in that CPU's bank and clears it in every other bank. Every CPU sees the same raw status.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset every enable word reads as zero and every `cpu_irq` bit is low.
- R2: The bank of CPU `c` starts at byte address `c × 8 × NUM_WORDS`. Word slots `0 … NUM_WORDS-1` of a bank are enable words, and slots `NUM_WORDS … 2×NUM_WORDS-1` are status words. Address bits [1:0] are ignored.
- R3: Word order within each group is reversed. Slot `k` of the enable group, and slot `NUM_WORDS+k` of the status group, both cover lines `32×(NUM_WORDS-1-k)` up to `32×(NUM_WORDS-1-k)+31`. Bit `b` of such a word is line `32×(NUM_WORDS-1-k)+b`.
- R4: A write to an enable word replaces all 32 bits of that word. Reading the word back returns the last value written.
- R5: A status word returns the synchronized raw level of its 32 lines, whatever the enable settings are.
- R6: `cpu_irq[c]` is a registered OR of (status AND CPU `c` enables). A change on `irq_in`, with the enables held, appears on `cpu_irq` at the third rising clock edge after it.
- R7: A change to an enable word takes effect on `cpu_irq` at the clock edge that follows the edge on which the write was accepted.
- R8: All CPUs see the same status. A line drives only the outputs of the CPUs whose enable bit for it is set.
- R9: Writes to status slots and to addresses beyond the last CPU bank change no register and no output. Reads of addresses beyond the last bank return zero.
- R10: `bus_ready` is always high. `rsp_valid` pulses for exactly the cycle after an accepted read, with `rsp_rdata` valid in that cycle. `rsp_valid` stays low after writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32×NUM_WORDS | Asynchronous level interrupt lines |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after request) |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt outputs |

## Verification
The in-design properties run on every cycle. They check the following:
- Each CPU output equals the previous cycle's masked OR.
- Enable words hold their value unless a matching write arrives.
- Writes to status slots or out-of-range addresses leave every enable untouched.
- Responses appear only after reads, and out-of-range reads return zero.
- Reset clears state.

Only the bench scenarios can show the following:
- The address arithmetic and the reversed word order, which require chosen line numbers to land in specific bits.
- The exact three-cycle input latency.
- Steering of a line from one CPU to another.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int LINES_PER_WORD = 32;
  typedef logic [LINES_PER_WORD-1:0] lirq_word_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/lirq_decode.sv
module lirq_decode #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 12,
  localparam int CPU_W    = lirq_pkg::idx_width(NUM_CPUS),
  localparam int GRP_W    = lirq_pkg::idx_width(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CPU_W-1:0]  cpu_sel,
  output logic              is_status,
  output logic [GRP_W-1:0]  group
);
  localparam int AW2 = ADDR_W - 2;
  localparam logic [AW2-1:0] BANK_SLOTS = AW2'(2 * NUM_WORDS);
  localparam logic [AW2-1:0] NW         = AW2'(NUM_WORDS);
  localparam logic [AW2-1:0] NC         = AW2'(NUM_CPUS);
  localparam logic [AW2-1:0] ONE        = AW2'(1);

  logic [AW2-1:0] word_addr;
  logic [AW2-1:0] bank_idx;
  logic [AW2-1:0] slot;
  logic [AW2-1:0] grp_full;
  logic [1:0]     unused_lo;

  assign unused_lo = addr[1:0];
  assign word_addr = addr[ADDR_W-1:2];
  assign bank_idx  = word_addr / BANK_SLOTS;
  assign slot      = word_addr % BANK_SLOTS;
  assign hit       = (bank_idx < NC);
  assign is_status = (slot >= NW);
  assign cpu_sel   = CPU_W'(bank_idx);

  // reversed order: lowest slot of a group holds the highest lines
  always_comb begin
    if (is_status) grp_full = BANK_SLOTS - ONE - slot;
    else           grp_full = NW - ONE - slot;
  end
  assign group = GRP_W'(grp_full);
endmodule

// File: rtl/lirq_bank.sv
module lirq_bank #(
  parameter int NUM_WORDS = 2,
  localparam int GRP_W    = lirq_pkg::idx_width(NUM_WORDS),
  localparam int LINES    = 32 * NUM_WORDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] wr_group,
  input  logic [31:0]      wr_data,
  input  logic [LINES-1:0] status,
  output logic [LINES-1:0] enable,
  output logic             irq
);
  lirq_pkg::lirq_word_t en_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                  en_q[g] <= '0;
      else if (wr_en && wr_group == GRP_W'(g))  en_q[g] <= wr_data;
    end
    assign enable[g*32 +: 32] = en_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & enable);
  end

  // R1
  en_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (enable == '0 && !irq));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(enable));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & enable)));
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 12,
  localparam int CPU_W    = lirq_pkg::idx_width(NUM_CPUS),
  localparam int GRP_W    = lirq_pkg::idx_width(NUM_WORDS),
  localparam int LINES    = 32 * NUM_WORDS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LINES-1:0]    irq_in,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic [NUM_CPUS-1:0] cpu_irq
);
  logic [LINES-1:0]                status_w;
  logic                            dec_hit;
  logic [CPU_W-1:0]                dec_cpu;
  logic                            dec_status;
  logic [GRP_W-1:0]                dec_group;
  logic [NUM_CPUS-1:0][LINES-1:0]  en_all;
  logic [NUM_CPUS-1:0]             wr_en;
  logic [LINES-1:0]                en_sel;
  logic [31:0]                     rd_word;

  assign bus_ready = 1'b1;

  lirq_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(status_w)
  );

  lirq_decode #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(dec_hit), .cpu_sel(dec_cpu),
    .is_status(dec_status), .group(dec_group)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign wr_en[c] = bus_valid && bus_write && dec_hit && !dec_status
                      && (dec_cpu == CPU_W'(c));
    lirq_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk(clk), .rst(rst), .wr_en(wr_en[c]), .wr_group(dec_group),
      .wr_data(bus_wdata), .status(status_w), .enable(en_all[c]),
      .irq(cpu_irq[c])
    );
  end

  always_comb begin
    en_sel = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (dec_cpu == CPU_W'(c)) en_sel = en_all[c];
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      if (dec_status) rd_word = status_w[dec_group*32 +: 32];
      else            rd_word = en_sel[dec_group*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid && !bus_write;
      rsp_rdata <= (bus_valid && !bus_write) ? rd_word : 32'h0;
    end
  end

  // R10
  rsp_only_reads_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_valid && !bus_write));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(!dec_hit)) |-> rsp_rdata == 32'h0);

  // R9
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && (!dec_hit || dec_status)) |=> $stable(en_all));

  // R10
  ready_high_chk: assert property (@(posedge clk) bus_ready);
endmodule

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  cpu_irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lvl_irq_router uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    check("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
    for (int a = 0; a < 2; a++) begin
      rd(12'(a*4), d, v);        check("R1 cpu0 enable reset", d, 32'h0);
      rd(12'(16 + a*4), d, v);   check("R1 cpu1 enable reset", d, 32'h0);
    end
  endtask

  task automatic t_enable_rw();
    logic [31:0] d; logic v;
    wr(12'h000, 32'hA5A5_0001);
    rd(12'h000, d, v); check("R4 enable readback", d, 32'hA5A5_0001);
    wr(12'h000, 32'h0000_00FF);
    rd(12'h000, d, v); check("R4 enable full replace", d, 32'h0000_00FF);
    rd(12'h010, d, v); check("R2 cpu1 bank separate", d, 32'h0);
    wr(12'h000, 32'h0);
  endtask

  task automatic t_map_order();
    logic [31:0] d; logic v;
    irq_in = 64'h8000_0000_0000_0001;
    tick(4);
    rd(12'h008, d, v); check("R3 status slot2 high lines", d, 32'h8000_0000);
    rd(12'h00C, d, v); check("R3 status slot3 lines 0-31", d, 32'h0000_0001);
    rd(12'h018, d, v); check("R8 cpu1 status same", d, 32'h8000_0000);
    rd(12'h01E, d, v); check("R2 low addr bits ignored", d, 32'h0000_0001);
    check("R5 status raw, outputs masked", 32'(cpu_irq), 32'h0);
    irq_in = '0;
    tick(4);
  endtask

  task automatic t_latency();
    wr(12'h004, 32'h1);          // cpu0 lines 0-31, bit 0
    tick(2);
    irq_in[0] = 1'b1;
    tick(1); check("R6 not after edge 1", 32'(cpu_irq), 32'h0);
    tick(1); check("R6 not after edge 2", 32'(cpu_irq), 32'h0);
    tick(1); check("R6 set after edge 3", 32'(cpu_irq), 32'h1);
    irq_in[0] = 1'b0;
    tick(2); check("R6 still high edge 2", 32'(cpu_irq), 32'h1);
    tick(1); check("R6 clear after edge 3", 32'(cpu_irq), 32'h0);
    wr(12'h004, 32'h0);
    tick(1);
  endtask

  task automatic t_enable_effect();
    irq_in[40] = 1'b1;           // slot 0 of bank, bit 8
    tick(4);
    wr(12'h010, 32'h0000_0100);
    check("R7 not yet at accept edge", 32'(cpu_irq), 32'h0);
    tick(1); check("R7 set one edge later", 32'(cpu_irq), 32'h2);
    wr(12'h010, 32'h0);
    tick(1); check("R7 cleared one edge later", 32'(cpu_irq), 32'h0);
    irq_in[40] = 1'b0;
    tick(4);
  endtask

  task automatic t_steer();
    irq_in[5] = 1'b1;
    wr(12'h004, 32'h20);
    tick(4); check("R8 line on cpu0 only", 32'(cpu_irq), 32'h1);
    wr(12'h004, 32'h0);
    wr(12'h014, 32'h20);
    tick(2); check("R8 line moved to cpu1", 32'(cpu_irq), 32'h2);
  endtask

  task automatic t_ignored();
    logic [31:0] d; logic v;
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFFFF_FFFF);
    tick(2);
    check("R9 outputs unchanged", 32'(cpu_irq), 32'h2);
    rd(12'h000, d, v); check("R9 cpu0 en slot0 intact", d, 32'h0);
    rd(12'h004, d, v); check("R9 cpu0 en slot1 intact", d, 32'h0);
    rd(12'h010, d, v); check("R9 cpu1 en slot0 intact", d, 32'h0);
    rd(12'h014, d, v); check("R9 cpu1 en slot1 intact", d, 32'h20);
    rd(12'h00C, d, v); check("R9 status not written", d, 32'h20);
    rd(12'h020, d, v); check("R9 out of range reads zero", d, 32'h0);
    irq_in = '0;
    wr(12'h014, 32'h0);
    tick(4);
  endtask

  task automatic t_read_timing();
    logic [31:0] d; logic v;
    check("R10 ready high", 32'(bus_ready), 32'h1);
    rd(12'h000, d, v); check("R10 rsp_valid after read", 32'(v), 32'h1);
    check("R10 rsp_valid one cycle only", 32'(rsp_valid), 32'h1);
    tick(1); check("R10 rsp_valid drops", 32'(rsp_valid), 32'h0);
    wr(12'h000, 32'h0);
    check("R10 no response to write", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_map_order();
    t_latency();
    t_enable_effect();
    t_steer();
    t_ignored();
    t_read_timing();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule